// File: doc/BRIEF.md
# Prioritised Pending Interrupt Selector

This block turns raw interrupt lines into per-CPU pending state and, for every CPU, chooses the one interrupt that should be presented next. Interrupt IDs 0 to 31 are private: each CPU has its own 32 private lines and its own pending, enable and priority state for them. Shared lines carry IDs 32 and up. A rising shared line marks its interrupt pending on every CPU named in that interrupt's target mask.

Each CPU looks at the interrupts that are both enabled and pending and picks the one with the smallest 8-bit priority value. That candidate is reported only if it beats the CPU's priority mask. The CPU's request line is raised only if the candidate also beats the CPU's running priority. Pending bits can also be set or cleared directly with one-cycle pulses. Acknowledge and completion are handled outside the block and drive those pulses and the running priority.

Top module: `irq_prio_select`

## Requirements
- R1: After reset every CPU reports ID 1023 (nothing pending), its request line is low, and all pending and stored-level state is zero.
- R2: Among the interrupts that are enabled and pending for a CPU, the one with the numerically smallest priority is chosen. On equal priority the lowest ID wins.
- R3: The chosen ID is reported only when its priority is strictly below that CPU's 8-bit mask (`prio_mask[c*8+:8]`). Otherwise the CPU reports 1023.
- R4: The request line rises only when a candidate is reported and its priority, widened to 9 bits, is strictly below the CPU's 9-bit running priority (`run_prio[c*9+:9]`). The value 0x100 means idle, and 0 blocks every request.
- R5: While `dist_en` is low, or the CPU's `cpu_en[c]` is low, that CPU reports 1023 and its request is low.
- R6: Shared line n is interrupt ID n+32. A rise on it sets pending only on the CPUs c whose bit `target[n*NUM_CPU+c]` is 1.
- R7: On a rise, pending is set if `edge_mode[id]` is 1 (edge), or if the interrupt is enabled for that CPU (`enable[c*NUM_IRQ+id]`). A level-mode rise seen while disabled leaves nothing pending, even if the interrupt is enabled later.
- R8: A falling line clears only its stored level and keeps pending. A line that stays at its stored level sets nothing, so a held-high line does not re-pend after a clear.
- R9: Private line `private_in[c*32+k]` affects only interrupt k on CPU c.
- R10: `pend_set` and `pend_clr` pulses act on bit `c*NUM_IRQ+id`. A set, whether from software or from a line rise, wins over a clear in the same cycle.
- R11: The outputs are registered. They reflect pending state, enables, priorities and thresholds as they stood before the previous clock edge, so a pending change shows up one clock after the edge that stored it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shared_in | input | NUM_IRQ-32 | Shared interrupt lines; line n is ID n+32 |
| private_in | input | NUM_CPU*32 | Private lines, 32 per CPU |
| enable | input | NUM_IRQ*NUM_CPU | Per-CPU enable per ID, bit c*NUM_IRQ+id |
| prio | input | NUM_IRQ*NUM_CPU*8 | Per-CPU priority per ID, byte c*NUM_IRQ+id |
| target | input | (NUM_IRQ-32)*NUM_CPU | CPU target mask per shared line |
| edge_mode | input | NUM_IRQ | 1 = edge, 0 = level, per ID |
| pend_set | input | NUM_IRQ*NUM_CPU | One-cycle pending set pulses |
| pend_clr | input | NUM_IRQ*NUM_CPU | One-cycle pending clear pulses |
| dist_en | input | 1 | Global distribution enable |
| cpu_en | input | NUM_CPU | Per-CPU interface enable |
| prio_mask | input | NUM_CPU*8 | Per-CPU priority mask |
| run_prio | input | NUM_CPU*9 | Per-CPU running priority, 0x100 = idle |
| hp_id | output | NUM_CPU*10 | Per-CPU highest-pending ID, 1023 = none |
| irq_req | output | NUM_CPU | Per-CPU interrupt request |

## Verification
Two functions can land in the same cycle: a line rise, or a software set, can mark a bit pending while a clear pulse for that same bit arrives. The directed part of the bench drives a clear together with a software set, and separately together with a private-line rise, on a bit whose state is visible at the output. The random part scatters sparse set and clear pulses over toggling lines, so such collisions happen often. In every case the bench judges the outcome against its own pending model, in which a set beats a clear, by comparing each CPU's reported ID and request line every cycle.

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_IRQ-33:0]            shared_in,
  input  logic [NUM_CPU*32-1:0]          private_in,
  input  logic [NUM_IRQ*NUM_CPU-1:0]     enable,
  input  logic [NUM_IRQ*NUM_CPU*8-1:0]   prio,
  input  logic [(NUM_IRQ-32)*NUM_CPU-1:0] target,
  input  logic [NUM_IRQ-1:0]             edge_mode,
  input  logic [NUM_IRQ*NUM_CPU-1:0]     pend_set,
  input  logic [NUM_IRQ*NUM_CPU-1:0]     pend_clr,
  input  logic                           dist_en,
  input  logic [NUM_CPU-1:0]             cpu_en,
  input  logic [NUM_CPU*8-1:0]           prio_mask,
  input  logic [NUM_CPU*9-1:0]           run_prio,
  output logic [NUM_CPU*10-1:0]          hp_id,
  output logic [NUM_CPU-1:0]             irq_req
);
  localparam int NSH    = NUM_IRQ - 32;
  localparam int NBIT   = NUM_IRQ * NUM_CPU;
  localparam int LEAVES = 1 << $clog2(NUM_IRQ);
  localparam logic [9:0] NONE = 10'd1023;

  logic [NSH-1:0]        sh_lvl;
  logic [NUM_CPU*32-1:0] pv_lvl;
  logic [NBIT-1:0]       pend, hw_set, pend_nx;
  logic [NSH-1:0]        sh_rise;
  logic [NUM_CPU*32-1:0] pv_rise;
  logic [NUM_CPU-1:0]    hit, fire;
  logic [9:0]            win_id [NUM_CPU];

  assign sh_rise = shared_in & ~sh_lvl;
  assign pv_rise = private_in & ~pv_lvl;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_set
    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_id
      if (k < 32) begin : g_priv
        assign hw_set[c*NUM_IRQ+k] = pv_rise[c*32+k]
                                   & (edge_mode[k] | enable[c*NUM_IRQ+k]);
      end else begin : g_shr
        assign hw_set[c*NUM_IRQ+k] = sh_rise[k-32] & target[(k-32)*NUM_CPU+c]
                                   & (edge_mode[k] | enable[c*NUM_IRQ+k]);
      end
    end
  end

  assign pend_nx = (pend & ~pend_clr) | pend_set | hw_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= '0;
      sh_lvl <= '0;
      pv_lvl <= '0;
    end else begin
      pend   <= pend_nx;
      sh_lvl <= shared_in;
      pv_lvl <= private_in;
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic       nv [1:2*LEAVES-1];
    logic [7:0] np [1:2*LEAVES-1];
    logic [9:0] ni [1:2*LEAVES-1];

    for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
      if (j < NUM_IRQ) begin : g_real
        assign nv[LEAVES+j] = pend[c*NUM_IRQ+j] & enable[c*NUM_IRQ+j];
        assign np[LEAVES+j] = prio[(c*NUM_IRQ+j)*8 +: 8];
        assign ni[LEAVES+j] = 10'(j);
      end else begin : g_pad
        assign nv[LEAVES+j] = 1'b0;
        assign np[LEAVES+j] = 8'hff;
        assign ni[LEAVES+j] = NONE;
      end
    end

    for (genvar i = 1; i < LEAVES; i++) begin : g_node
      logic take_l;
      assign take_l = nv[2*i] & (~nv[2*i+1] | (np[2*i] <= np[2*i+1]));
      assign nv[i]  = nv[2*i] | nv[2*i+1];
      assign np[i]  = take_l ? np[2*i] : np[2*i+1];
      assign ni[i]  = take_l ? ni[2*i] : ni[2*i+1];
    end

    assign hit[c]    = dist_en & cpu_en[c] & nv[1] & (np[1] < prio_mask[c*8 +: 8]);
    assign fire[c]   = hit[c] & ({1'b0, np[1]} < run_prio[c*9 +: 9]);
    assign win_id[c] = ni[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CPU; c++) hp_id[c*10 +: 10] <= NONE;
      irq_req <= '0;
    end else begin
      for (int c = 0; c < NUM_CPU; c++)
        hp_id[c*10 +: 10] <= hit[c] ? win_id[c] : NONE;
      irq_req <= fire;
    end
  end
endmodule

// File: rtl/irq_prio_select_chk.sv
module irq_prio_select_chk #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  dist_en,
  input logic [NUM_CPU-1:0]    cpu_en,
  input logic [NUM_CPU*8-1:0]  prio_mask,
  input logic [NUM_CPU*9-1:0]  run_prio,
  input logic [NUM_CPU*10-1:0] hp_id,
  input logic [NUM_CPU-1:0]    irq_req
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
    assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!dist_en || !cpu_en[c]) |=> (!irq_req[c] && hp_id[c*10 +: 10] == 10'd1023));

    assert_idle_no_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hp_id[c*10 +: 10] == 10'd1023) |-> !irq_req[c]);

    assert_mask_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (prio_mask[c*8 +: 8] == 8'd0) |=> (hp_id[c*10 +: 10] == 10'd1023));

    assert_run_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_prio[c*9 +: 9] == 9'd0) |=> !irq_req[c]);
  end
endmodule

bind irq_prio_select irq_prio_select_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
  .prio_mask(prio_mask), .run_prio(run_prio), .hp_id(hp_id), .irq_req(irq_req)
);

// File: tb/irq_prio_select_bench.sv
`timescale 1ns/1ps
module irq_prio_select_bench;
  localparam int NI = 64;
  localparam int NC = 2;
  localparam int NS = NI - 32;
  localparam int NB = NI * NC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0]    shared_in = '0;
  logic [NC*32-1:0] private_in = '0;
  logic [NB-1:0]    enable = '0;
  logic [NB*8-1:0]  prio;
  logic [NS*NC-1:0] target = '0;
  logic [NI-1:0]    edge_mode = '0;
  logic [NB-1:0]    pend_set = '0;
  logic [NB-1:0]    pend_clr = '0;
  logic             dist_en = 1'b1;
  logic [NC-1:0]    cpu_en = '1;
  logic [NC*8-1:0]  prio_mask;
  logic [NC*9-1:0]  run_prio;
  logic [NC*10-1:0] hp_id;
  logic [NC-1:0]    irq_req;

  bit [NB-1:0]    m_pend = '0;
  bit [NS-1:0]    m_sl = '0;
  bit [NC*32-1:0] m_pl = '0;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_prio_select #(.NUM_IRQ(NI), .NUM_CPU(NC)) u_irq_prio_select (
    .clk(clk), .rst_n(rst_n), .shared_in(shared_in), .private_in(private_in),
    .enable(enable), .prio(prio), .target(target), .edge_mode(edge_mode),
    .pend_set(pend_set), .pend_clr(pend_clr), .dist_en(dist_en), .cpu_en(cpu_en),
    .prio_mask(prio_mask), .run_prio(run_prio), .hp_id(hp_id), .irq_req(irq_req)
  );

  task automatic step(string tag);
    logic [9:0] eh [NC];
    logic       er [NC];
    bit [NB-1:0] nx;
    for (int c = 0; c < NC; c++) begin
      int best = 256;
      int bid = 1023;
      for (int k = 0; k < NI; k++)
        if (m_pend[c*NI+k] && enable[c*NI+k] && int'(prio[(c*NI+k)*8 +: 8]) < best) begin
          best = int'(prio[(c*NI+k)*8 +: 8]);
          bid = k;
        end
      eh[c] = 10'd1023;
      er[c] = 1'b0;
      if (dist_en && cpu_en[c] && bid != 1023 && best < int'(prio_mask[c*8 +: 8])) begin
        eh[c] = 10'(bid);
        er[c] = best < int'(run_prio[c*9 +: 9]);
      end
    end
    nx = (m_pend & ~pend_clr) | pend_set;
    for (int c = 0; c < NC; c++)
      for (int k = 0; k < NI; k++) begin
        bit rise;
        bit aim;
        if (k < 32) begin
          rise = private_in[c*32+k] && !m_pl[c*32+k];
          aim = 1'b1;
        end else begin
          rise = shared_in[k-32] && !m_sl[k-32];
          aim = target[(k-32)*NC+c];
        end
        if (rise && aim && (edge_mode[k] || enable[c*NI+k])) nx[c*NI+k] = 1'b1;
      end
    m_pend = nx;
    m_sl = shared_in;
    m_pl = private_in;
    @(posedge clk);
    @(negedge clk);
    pend_set = '0;
    pend_clr = '0;
    for (int c = 0; c < NC; c++) begin
      checks++;
      if (hp_id[c*10 +: 10] !== eh[c] || irq_req[c] !== er[c]) begin
        failures++;
        $display("FAIL %s cpu%0d actual hp=%0d req=%0b expected hp=%0d req=%0b",
                 tag, c, hp_id[c*10 +: 10], irq_req[c], eh[c], er[c]);
      end
    end
  endtask

  task automatic expect_out(int c, int id, bit req, string tag);
    checks++;
    if (hp_id[c*10 +: 10] !== 10'(id) || irq_req[c] !== req) begin
      failures++;
      $display("FAIL %s cpu%0d actual hp=%0d req=%0b expected hp=%0d req=%0b",
               tag, c, hp_id[c*10 +: 10], irq_req[c], id, req);
    end
  endtask

  task automatic clear_all(string tag);
    pend_clr = '1;
    step(tag);
    step(tag);
  endtask

  function automatic void set_prio(int c, int k, int v);
    prio[(c*NI+k)*8 +: 8] = 8'(v);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NB; i++) prio[i*8 +: 8] = 8'h80;
    for (int c = 0; c < NC; c++) begin
      prio_mask[c*8 +: 8] = 8'hff;
      run_prio[c*9 +: 9] = 9'h100;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out(0, 1023, 0, "R1");
    expect_out(1, 1023, 0, "R1");

    // R2: priority order and lowest-ID tie break
    enable[0*NI+35] = 1; enable[0*NI+40] = 1; enable[0*NI+50] = 1;
    set_prio(0, 35, 8'h20); set_prio(0, 40, 8'h20); set_prio(0, 50, 8'h10);
    pend_set[0*NI+35] = 1; pend_set[0*NI+40] = 1;
    step("R2"); step("R2");
    expect_out(0, 35, 1, "R2");
    pend_set[0*NI+50] = 1;
    step("R2"); step("R2");
    expect_out(0, 50, 1, "R2");
    pend_clr[0*NI+50] = 1;
    step("R2"); step("R2");

    // R3: mask is strict
    prio_mask[0 +: 8] = 8'h20;
    step("R3");
    expect_out(0, 1023, 0, "R3");
    prio_mask[0 +: 8] = 8'h21;
    step("R3");
    expect_out(0, 35, 1, "R3");
    prio_mask[0 +: 8] = 8'hff;

    // R4: running priority is strict
    run_prio[0 +: 9] = 9'h020;
    step("R4");
    expect_out(0, 35, 0, "R4");
    run_prio[0 +: 9] = 9'h021;
    step("R4");
    expect_out(0, 35, 1, "R4");
    run_prio[0 +: 9] = 9'h100;

    // R5: global and per-CPU gating
    dist_en = 0;
    step("R5");
    expect_out(0, 1023, 0, "R5");
    dist_en = 1;
    cpu_en[0] = 0;
    step("R5");
    expect_out(0, 1023, 0, "R5");
    cpu_en[0] = 1;
    step("R5");

    // R11: one-clock latency of a pending change
    clear_all("R11");
    pend_set[0*NI+40] = 1;
    step("R11");
    expect_out(0, 1023, 0, "R11");
    step("R11");
    expect_out(0, 40, 1, "R11");

    // R10: set beats clear in the same cycle
    pend_set[0*NI+40] = 1; pend_clr[0*NI+40] = 1;
    step("R10"); step("R10");
    expect_out(0, 40, 1, "R10");
    clear_all("R10");
    edge_mode[7] = 1; enable[0*NI+7] = 1;
    private_in[7] = 1; pend_clr[0*NI+7] = 1;
    step("R10"); step("R10");
    expect_out(0, 7, 1, "R10");
    private_in[7] = 0;
    clear_all("R10");

    // R6: shared line target mask
    target[10*NC+1] = 1;
    enable[0*NI+42] = 1; enable[1*NI+42] = 1;
    set_prio(0, 42, 8'h30); set_prio(1, 42, 8'h30);
    shared_in[10] = 1;
    step("R6"); step("R6");
    expect_out(1, 42, 1, "R6");
    expect_out(0, 1023, 0, "R6");

    // R8: falling edge keeps pending; steady high ignored
    shared_in[10] = 0;
    step("R8"); step("R8");
    expect_out(1, 42, 1, "R8");
    pend_clr[1*NI+42] = 1;
    step("R8"); step("R8");
    expect_out(1, 1023, 0, "R8");
    shared_in[10] = 1;
    step("R8"); step("R8");
    expect_out(1, 42, 1, "R8");
    pend_clr[1*NI+42] = 1;
    step("R8"); step("R8"); step("R8");
    expect_out(1, 1023, 0, "R8");
    shared_in[10] = 0;
    clear_all("R8");

    // R7: level mode needs enable at the rise; edge mode does not
    target[13*NC+0] = 1; target[13*NC+1] = 1;
    enable[0*NI+45] = 0; enable[1*NI+45] = 1;
    shared_in[13] = 1;
    step("R7"); step("R7");
    expect_out(1, 45, 1, "R7");
    expect_out(0, 1023, 0, "R7");
    enable[0*NI+45] = 1;
    step("R7"); step("R7");
    expect_out(0, 1023, 0, "R7");
    enable[0*NI+45] = 0;
    shared_in[13] = 0;
    step("R7");
    edge_mode[45] = 1;
    shared_in[13] = 1;
    step("R7");
    enable[0*NI+45] = 1;
    step("R7"); step("R7");
    expect_out(0, 45, 1, "R7");
    shared_in[13] = 0;
    clear_all("R7");

    // R9: private line reaches only its own CPU
    edge_mode[5] = 1; enable[0*NI+5] = 1; enable[1*NI+5] = 1;
    private_in[1*32+5] = 1;
    step("R9"); step("R9");
    expect_out(1, 5, 1, "R9");
    expect_out(0, 1023, 0, "R9");
    private_in[1*32+5] = 0;
    clear_all("R9");

    // Random mix checked against the bench model (R2, R6, R7, R8, R10)
    for (int i = 0; i < NB; i++) prio[i*8 +: 8] = 8'($urandom_range(0, 7));
    for (int n = 0; n < 3000; n++) begin
      for (int b = 0; b < NS; b++) if ($urandom_range(0, 99) < 6) shared_in[b] = ~shared_in[b];
      for (int b = 0; b < NC*32; b++) if ($urandom_range(0, 99) < 6) private_in[b] = ~private_in[b];
      for (int b = 0; b < NB; b++) begin
        pend_set[b] = ($urandom_range(0, 199) < 2);
        pend_clr[b] = ($urandom_range(0, 99) < 5);
        if ($urandom_range(0, 99) < 3) enable[b] = ~enable[b];
        if ($urandom_range(0, 199) < 1) prio[b*8 +: 8] = 8'($urandom_range(0, 7));
      end
      for (int b = 0; b < NI; b++) if ($urandom_range(0, 199) < 2) edge_mode[b] = ~edge_mode[b];
      for (int b = 0; b < NS*NC; b++) if ($urandom_range(0, 199) < 2) target[b] = ~target[b];
      for (int c = 0; c < NC; c++) begin
        if ($urandom_range(0, 99) < 3) prio_mask[c*8 +: 8] = 8'($urandom_range(0, 9));
        if ($urandom_range(0, 99) < 3)
          run_prio[c*9 +: 9] = ($urandom_range(0, 3) == 0) ? 9'h100 : 9'($urandom_range(0, 9));
        if ($urandom_range(0, 99) < 1) cpu_en[c] = ~cpu_en[c];
      end
      if ($urandom_range(0, 199) < 1) dist_en = ~dist_en;
      if (dist_en == 0 && $urandom_range(0, 9) < 3) dist_en = 1;
      step("R2 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule